// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the byte-wide, memory-mapped register face of a serial port. A host addresses it with a 3-bit offset and separate read and write strobes. Behind it sits a bare transmit and receive core that only shifts bits. The front end holds the character-format, FIFO-enable and interrupt-mask settings, and the 16-bit baud divisor. It also provides a one-byte holding slot in each direction, a status byte the host can poll, and an interrupt line that fires when a received byte is waiting.

Offsets 0 and 1 are banked. While the divisor-access bit (bit 7 of the format register) is set, they reach the low and high divisor bytes. While it is clear, offset 0 is the data port and offset 1 is the interrupt mask. A divider turns the divisor into a one-cycle tick at 16 times the bit rate, so the divisor is ceil(f_clk / (16 × baud)). For example, 22.729 MHz and 2400 baud give 592. The core pulls transmit bytes with a take strobe and hands received bytes over with a push strobe.

Top module: `serial_reg_front`

## Requirements
- R1: After reset every stored register is 0: offset 3 reads 0x00, offset 1 reads 0x00, the status byte at offset 5 reads 0x20, irq is 0 and tx_valid is 0.
- R2: With bit 7 of the offset-3 register set, offsets 0 and 1 read and write the low and high divisor bytes, and a write to offset 0 does not load the transmit slot. With it clear, offset 1 is the interrupt mask: only bits 3:0 are stored and bits 7:4 read 0.
- R3: Offset 3 stores and reads back all 8 bits, and its bits 1:0 appear on char_len (3 selects 8-bit characters).
- R4: A write to offset 2 stores only bit 0, which drives fifo_en. Offset 2 reads {7'b0, bit 0}.
- R5: The cycle after rx_push, status bit 0 (data ready) is 1, and offset 0 (bit 7 of offset 3 clear) reads the pushed byte.
- R6: A read of offset 0 with bit 7 of offset 3 clear returns the byte, and data ready is 0 from the next cycle. The same read with the bit set leaves data ready alone. A push in the same cycle as the read wins, so data ready stays 1 and the new byte is kept.
- R7: A write to offset 0 (bit 7 clear) into an empty slot makes tx_valid 1 and status bit 5 (holding empty) 0 from the next cycle, with the byte on tx_byte. tx_take while tx_valid is high makes bit 5 1 and tx_valid 0 from the next cycle.
- R8: A data write while the transmit slot is full and not being taken in that cycle is ignored, and tx_byte keeps the first byte.
- R9: baud_tick is a one-cycle pulse repeating every D clock cycles, where D is the 16-bit divisor {high, low}. A divisor of 0 behaves as 1.
- R10: irq is 1 exactly when data ready is 1 and interrupt-mask bit 0 is 1.
- R11: Writes to offsets 4 to 7 change nothing, and reads of offsets 4, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| tx_byte | output | 8 | Byte in the transmit slot |
| tx_valid | output | 1 | Transmit slot holds a byte |
| tx_take | input | 1 | Core takes the transmit byte |
| rx_byte | input | 8 | Byte from the receive core |
| rx_push | input | 1 | Receive core delivers rx_byte |
| baud_tick | output | 1 | 16x oversampling tick |
| char_len | output | 2 | Character length field |
| fifo_en | output | 1 | FIFO enable |
| irq | output | 1 | Received-data interrupt |

## Verification
A wrong bank select shows at once on the next read: a divisor byte appears where the interrupt mask should be, or a data write loads the transmit slot while divisor access is open. A stuck data-ready or holding-empty flag shows in the status byte, and on irq or tx_valid, the cycle after the push, read, write or take that should have moved it. A faulty reload in the divider shows as a gap between ticks that differs from the divisor, seen within one tick period. Checking the gap at 0, 5 and 592 exposes errors in the zero case and in the high byte.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_FIFO = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_FMT  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd5;

  localparam int FMT_DIV_ACCESS = 7;
  localparam int STAT_READY     = 0;
  localparam int STAT_TX_EMPTY  = 5;
  localparam int MASK_W         = 4;
endpackage

// File: rtl/serial_baud_gen.sv
module serial_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_eff;

  always_comb begin
    div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
    tick    = (cnt_q == '0);
    cnt_d   = tick ? (div_eff - DIV_W'(1)) : (cnt_q - DIV_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // A reload with a divisor above one leaves at least one quiet cycle
  p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > DIV_W'(1)) |=> !tick);
  // Divisor 0 or 1 keeps the tick high every cycle
  p_tick_zero_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor <= DIV_W'(1)) |=> tick);
endmodule

// File: rtl/serial_tx_slot.sv
module serial_tx_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_q,
  output logic              full_q
);
  logic accept, full_d;

  always_comb begin
    accept = load && (!full_q || take);
    if (accept)               full_d = 1'b1;
    else if (take && full_q)  full_d = 1'b0;
    else                      full_d = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (accept) hold_q <= load_data;
  end

  p_load_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !full_q) |=> (full_q && hold_q == $past(load_data)));
  p_take_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && full_q && !load) |=> !full_q);
  p_full_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && load && !take) |=> (full_q && $stable(hold_q)));
endmodule

// File: rtl/serial_rx_slot.sv
module serial_rx_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              consume,
  output logic [DATA_W-1:0] buf_q,
  output logic              ready_q
);
  logic ready_d;

  always_comb begin
    if (push)         ready_d = 1'b1;
    else if (consume) ready_d = 1'b0;
    else              ready_d = ready_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    buf_q <= '0;
    else if (push) buf_q <= push_data;
  end

  p_push_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (ready_q && buf_q == $past(push_data)));
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !push) |=> !ready_q);
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import serial_reg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] tx_byte,
  output logic          tx_valid,
  input  logic          tx_take,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_push,
  output logic          baud_tick,
  output logic [1:0]    char_len,
  output logic          fifo_en,
  output logic          irq
);
  localparam int DIV_W = 2 * DW;

  logic [DW-1:0]     fmt_q, fmt_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              fifo_q, fifo_d;
  logic [DW-1:0]     div_lo_q, div_lo_d, div_hi_q, div_hi_d;
  logic              div_open;
  logic              wr_data, wr_lo, wr_mask, wr_hi, wr_fifo, wr_fmt;
  logic              rd_data;
  logic [DW-1:0]     rx_buf, stat;
  logic              rx_ready, tx_full;

  // Decode, banked on the divisor-access bit
  always_comb begin
    div_open = fmt_q[FMT_DIV_ACCESS];
    wr_data  = wr_en && addr == OFS_DATA && !div_open;
    wr_lo    = wr_en && addr == OFS_DATA &&  div_open;
    wr_mask  = wr_en && addr == OFS_MASK && !div_open;
    wr_hi    = wr_en && addr == OFS_MASK &&  div_open;
    wr_fifo  = wr_en && addr == OFS_FIFO;
    wr_fmt   = wr_en && addr == OFS_FMT;
    rd_data  = rd_en && addr == OFS_DATA && !div_open;
  end

  // Next state with explicit enables
  always_comb begin
    fmt_d    = wr_fmt  ? wdata             : fmt_q;
    mask_d   = wr_mask ? wdata[MASK_W-1:0] : mask_q;
    fifo_d   = wr_fifo ? wdata[0]          : fifo_q;
    div_lo_d = wr_lo   ? wdata             : div_lo_q;
    div_hi_d = wr_hi   ? wdata             : div_hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q    <= '0;
      mask_q   <= '0;
      fifo_q   <= 1'b0;
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else begin
      fmt_q    <= fmt_d;
      mask_q   <= mask_d;
      fifo_q   <= fifo_d;
      div_lo_q <= div_lo_d;
      div_hi_q <= div_hi_d;
    end
  end

  serial_tx_slot #(.DATA_W(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(wr_data), .load_data(wdata),
    .take(tx_take), .hold_q(tx_byte), .full_q(tx_full)
  );

  serial_rx_slot #(.DATA_W(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_byte),
    .consume(rd_data), .buf_q(rx_buf), .ready_q(rx_ready)
  );

  serial_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor({div_hi_q, div_lo_q}), .tick(baud_tick)
  );

  always_comb begin
    stat                = '0;
    stat[STAT_READY]    = rx_ready;
    stat[STAT_TX_EMPTY] = !tx_full;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_DATA: rdata = div_open ? div_lo_q : rx_buf;
      OFS_MASK: rdata = div_open ? div_hi_q : DW'(mask_q);
      OFS_FIFO: rdata = DW'(fifo_q);
      OFS_FMT:  rdata = fmt_q;
      OFS_STAT: rdata = stat;
      default:  rdata = '0;
    endcase
  end

  assign tx_valid = tx_full;
  assign char_len = fmt_q[1:0];
  assign fifo_en  = fifo_q;
  assign irq      = rx_ready & mask_q[0];

  // irq only rises after a push or a mask write, only falls after a data read or a mask write
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(rx_push) || $past(wr_mask)));
  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(rd_data) || $past(wr_mask)));
  // Data-port writes with divisor access open never touch the transmit slot
  p_bank_keeps_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DATA && div_open && !tx_take) |=> $stable(tx_valid));
endmodule

// File: tb/sim_serial_reg_front.sv
module sim_serial_reg_front;
  localparam int CLK_P = 10;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, tx_take = 1'b0, rx_push = 1'b0;
  logic [7:0] wdata = '0, rx_byte = '0;
  logic [7:0] rdata, tx_byte;
  logic       tx_valid, baud_tick, fifo_en, irq;
  logic [1:0] char_len;

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   vecs = 0, errs = 0;
  logic chk_req = 1'b0;
  int   gap = 0;
  bit   done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  serial_reg_front u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_take(tx_take), .rx_byte(rx_byte), .rx_push(rx_push),
    .baud_tick(baud_tick), .char_len(char_len), .fifo_en(fifo_en), .irq(irq)
  );

  function automatic logic [15:0] pick(int sel);
    case (sel)
      0: return 16'(rdata);
      1: return 16'(tx_valid);
      2: return 16'(tx_byte);
      3: return 16'(irq);
      4: return 16'(char_len);
      5: return 16'(fifo_en);
      default: return 16'(gap);
    endcase
  endfunction

  // Monitor: pops an expected item whenever a read or probe is in flight
  initial forever begin
    @(negedge clk);
    #(CLK_P/4);
    if (rd_en || chk_req) begin
      exp_t e;
      logic [15:0] act;
      e = sb_q.pop_front();
      act = pick(e.sel);
      vecs++;
      if (act !== e.exp) begin
        errs++;
        $display("FAIL %s: actual %0h expected %0h", e.tag, act, e.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    sb_q.push_back('{0, 16'(exp), tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic probe(input int sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    sb_q.push_back('{sel, exp, tag});
    chk_req = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  task automatic wait_tick();
    do begin
      @(negedge clk);
      #(CLK_P/4);
    end while (!baud_tick);
  endtask

  task automatic set_div(input logic [15:0] d);
    wr(3'd3, 8'h83);
    wr(3'd0, d[7:0]);
    wr(3'd1, d[15:8]);
    wr(3'd3, 8'h03);
  endtask

  task automatic measure(input logic [15:0] expect_gap, input string tag);
    int g;
    wait_tick();
    wait_tick();
    g = 0;
    do begin
      @(negedge clk);
      #(CLK_P/4);
      g++;
    end while (!baud_tick);
    gap = g;
    probe(6, expect_gap, tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd3, 8'h00, "R1 format reg");
    rd(3'd1, 8'h00, "R1 mask reg");
    rd(3'd5, 8'h20, "R1 status");
    probe(3, 16'd0, "R1 irq");
    probe(1, 16'd0, "R1 tx_valid");
    measure(16'd1, "R1 R9 zero divisor tick");

    // R3 format register
    wr(3'd3, 8'h03);
    rd(3'd3, 8'h03, "R3 readback");
    probe(4, 16'd3, "R3 char_len");
    wr(3'd3, 8'h5E);
    rd(3'd3, 8'h5E, "R3 full byte");
    probe(4, 16'd2, "R3 char_len 2");
    wr(3'd3, 8'h03);

    // R4 fifo control
    wr(3'd2, 8'hC7);
    rd(3'd2, 8'h01, "R4 fifo readback");
    probe(5, 16'd1, "R4 fifo_en");
    wr(3'd2, 8'hFE);
    probe(5, 16'd0, "R4 fifo_en off");

    // R2 banking
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R2 mask width");
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h50);
    wr(3'd1, 8'h02);
    rd(3'd0, 8'h50, "R2 div low");
    rd(3'd1, 8'h02, "R2 div high");
    probe(1, 16'd0, "R2 no tx load while banked");
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h0F, "R2 mask intact");
    measure(16'd592, "R9 divisor 592");

    // R5 / R10 receive and interrupt
    push(8'hA5);
    rd(3'd5, 8'h21, "R5 data ready");
    probe(3, 16'd1, "R10 irq on");
    wr(3'd1, 8'h00);
    probe(3, 16'd0, "R10 irq masked");
    wr(3'd1, 8'h01);
    probe(3, 16'd1, "R10 irq unmasked");
    rd(3'd0, 8'hA5, "R5 byte");
    rd(3'd5, 8'h20, "R6 ready cleared");
    probe(3, 16'd0, "R10 irq after read");

    // R6 banked read does not clear, push beats read
    push(8'h3C);
    wr(3'd3, 8'h83);
    rd(3'd0, 8'h50, "R6 banked read gives div low");
    wr(3'd3, 8'h03);
    rd(3'd5, 8'h21, "R6 ready kept");
    @(negedge clk);
    addr = 3'd0; rd_en = 1'b1; rx_byte = 8'h99; rx_push = 1'b1;
    sb_q.push_back('{0, 16'h003C, "R6 read during push"});
    @(negedge clk);
    rd_en = 1'b0; rx_push = 1'b0;
    rd(3'd5, 8'h21, "R6 push wins");
    rd(3'd0, 8'h99, "R6 new byte");
    rd(3'd5, 8'h20, "R6 cleared");

    // R7 / R8 transmit
    wr(3'd0, 8'h77);
    probe(1, 16'd1, "R7 tx_valid");
    probe(2, 16'h77, "R7 tx_byte");
    rd(3'd5, 8'h00, "R7 holding not empty");
    wr(3'd0, 8'h88);
    probe(2, 16'h77, "R8 write while full ignored");
    take();
    probe(1, 16'd0, "R7 tx_valid after take");
    rd(3'd5, 8'h20, "R7 holding empty");

    // R11 unused offsets
    wr(3'd5, 8'h00);
    rd(3'd5, 8'h20, "R11 status write ignored");
    wr(3'd7, 8'hFF);
    rd(3'd7, 8'h00, "R11 offset 7");
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h00, "R11 offset 4");
    rd(3'd6, 8'h00, "R11 offset 6");
    rd(3'd3, 8'h03, "R11 format untouched");

    // R9 other divisors
    set_div(16'd5);
    measure(16'd5, "R9 divisor 5");
    set_div(16'd0);
    measure(16'd1, "R9 divisor 0");
    set_div(16'd1);
    measure(16'd1, "R9 divisor 1");

    @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule